// File: doc/BRIEF.md
# Subtract-and-Branch Single-Instruction Processor

This block is a small processor whose whole instruction set is one operation. An instruction is three consecutive words in a shared, word-addressed memory. Read in order, they are a source address, a target address and a jump address. Executing it reads both data words and stores target minus source back at the target address. The sign of that difference then decides the next program counter: either the jump address, or the current counter plus three. The machine stops for good once the program counter takes a negative value. Program and data share the memory, so a program can rewrite its own operands.

A multi-cycle sequencer runs each instruction over a single-port synchronous RAM, making at most one memory access per step. The instruction is split into three operand fetches, two data reads, a write-back and a counter update. A parameter picks the branch rule: taken on a result of zero or below, or only on a strictly negative result. A host port fills memory while the core is held in reset. The same port reads memory back whenever the core is stopped or stalled. An enable input lets the core start a new instruction only while it is high.

Top module: `subbr_cpu`

## Requirements
- R1: While reset is held and at the first clock after its release, `pc` is 0 and `halted` is 0.
- R2: Each instruction with operand words a, b, c writes Mem[b] - Mem[a], truncated to W bits in two's complement, to location b. Address operands use their low address bits.
- R3: With ZERO_TAKES=1, a result whose sign bit is set or which equals zero loads `pc` with operand c.
- R4: When the branch is not taken, `pc` advances by 3 to the next instruction.
- R5: With ZERO_TAKES=0, only a negative result branches, and a zero result falls through to `pc`+3.
- R6: When `pc` takes a value with its sign bit set (for example c = 16'hFFFF), `halted` goes to 1. It then stays at 1, `pc` holds its value and no further memory write occurs.
- R7: Every instruction takes exactly 7 clock cycles. `pc` changes only at the end of the seventh, so a two-instruction program that halts raises `halted` on the 14th rising edge after reset release.
- R8: While `running` is 0, the core does not start a new instruction: `pc` holds and memory is unchanged.
- R9: `host_we` writes `host_wdata` to `host_addr` only while `rst_n` is 0. Out of reset it has no effect on memory.
- R10: While reset is held, or after the core has halted or stalled, `host_rdata` shows Mem[`host_addr`] one clock after the address is applied.
- R11: A write-back to a word that a later instruction fetches as an operand changes that instruction's behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; enables host preload |
| running | input | 1 | Allows the core to start the next instruction |
| host_we | input | 1 | Host write strobe, honoured only in reset |
| host_addr | input | AW | Host word address for preload and readback |
| host_wdata | input | W | Host write data |
| host_rdata | output | W | Registered memory read data |
| pc | output | W | Program counter |
| halted | output | 1 | Set once the program counter goes negative |

## Verification
The branch decision and halt detection fall in the same cycle when a taken branch targets a negative address. The update step then has to pick the jump operand and recognise the stop condition together. Every bench program ends in an instruction whose result is negative and whose jump word is 16'hFFFF. A second copy of the core, built with the strict-negative rule, runs the same programs, so a zero result separates the two rules within one instruction. Each run is judged after the stop by reading memory back: the difference, which of two marker words changed, and the final counter value. A timed run checks that the stop is flagged on the exact edge.

// File: rtl/subbr_pkg.sv
// Package: shared step encoding for the subtract-and-branch processor.
// Assumes: one step per clock; ST_HALT is terminal until reset.
package subbr_pkg;

    typedef enum logic [2:0] {
        ST_FETCH_A   = 3'd0,
        ST_FETCH_B   = 3'd1,
        ST_FETCH_C   = 3'd2,
        ST_READ_A    = 3'd3,
        ST_READ_B    = 3'd4,
        ST_WRITE     = 3'd5,
        ST_UPDATE_PC = 3'd6,
        ST_HALT      = 3'd7
    } step_e;

endpackage

// File: rtl/subbr_ram.sv
// Module: single-port synchronous RAM, one access per clock.
// Read data is registered (one cycle latency). Locations at or beyond DEPTH
// read as zero and ignore writes. Read-during-write returns the old word.
module subbr_ram #(
    parameter int W     = 16,
    parameter int DEPTH = 384,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic         in_range;

    // Purpose: flag addresses that map onto a real location.
    always_comb in_range = ({1'b0, addr} < DEPTH_V);

    // Purpose: perform the write and register the read word.
    always_ff @(posedge clk) begin
        if (we && in_range) begin
            mem[addr] <= wdata;
        end
        rdata <= in_range ? mem[addr] : '0;
    end

endmodule

// File: rtl/subbr_alu.sv
// Module: subtractor and branch-condition unit.
// Produces minuend - subtrahend (wrapping) and the branch flag. ZERO_TAKES
// selects whether a zero result branches (1) or only negative ones (0).
module subbr_alu #(
    parameter int W          = 16,
    parameter bit ZERO_TAKES = 1'b1
) (
    input  logic [W-1:0] minuend,
    input  logic [W-1:0] subtrahend,
    output logic [W-1:0] diff,
    output logic         take
);

    // Purpose: two's complement difference.
    always_comb diff = minuend - subtrahend;

    generate
        if (ZERO_TAKES) begin : g_le_zero
            // Purpose: branch on negative or zero.
            always_comb take = diff[W-1] | (diff == '0);
        end else begin : g_lt_zero
            // Purpose: branch on negative only.
            always_comb take = diff[W-1];
        end
    endgenerate

endmodule

// File: rtl/subbr_seq.sv
// Module: instruction sequencer, program counter and operand registers.
// Steps through fetch a, b, c, read Mem[a], read Mem[b] plus write-back, and
// counter update. Assumes AW <= W and a memory with one cycle read latency.
// New instructions start only while `running` is high; a negative counter
// parks the machine in ST_HALT until reset.
module subbr_seq
    import subbr_pkg::*;
#(
    parameter int W          = 16,
    parameter int AW         = 9,
    parameter bit ZERO_TAKES = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          running,
    input  logic [W-1:0]  mem_q,
    input  logic [W-1:0]  diff,
    input  logic          take,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [W-1:0]  mem_wdata,
    output logic          core_owns,
    output logic [W-1:0]  minuend,
    output logic [W-1:0]  subtrahend,
    output logic [W-1:0]  pc,
    output logic          halted
);

    step_e        st;
    logic [W-1:0] op_a, op_b, op_c, val_a, res_q;
    logic         take_q;
    logic [W-1:0] pc_p1, pc_p2, pc_next;

    // Purpose: successor addresses of the current instruction.
    always_comb begin
        pc_p1   = pc + W'(1);
        pc_p2   = pc + W'(2);
        pc_next = take_q ? op_c : pc + W'(3);
    end

    // Purpose: memory address, strobe and write data for the current step.
    always_comb begin
        unique case (st)
            ST_FETCH_B: mem_addr = pc_p1[AW-1:0];
            ST_FETCH_C: mem_addr = pc_p2[AW-1:0];
            ST_READ_A:  mem_addr = op_a[AW-1:0];
            ST_READ_B:  mem_addr = op_b[AW-1:0];
            ST_WRITE:   mem_addr = op_b[AW-1:0];
            default:    mem_addr = pc[AW-1:0];
        endcase
        mem_we     = (st == ST_WRITE);
        mem_wdata  = diff;
        minuend    = mem_q;
        subtrahend = val_a;
        core_owns  = (st != ST_HALT) && !((st == ST_FETCH_A) && !running);
        halted     = (st == ST_HALT);
    end

    // Purpose: advance the step machine and capture operands and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_FETCH_A;
            pc     <= '0;
            op_a   <= '0;
            op_b   <= '0;
            op_c   <= '0;
            val_a  <= '0;
            res_q  <= '0;
            take_q <= 1'b0;
        end else begin
            unique case (st)
                ST_FETCH_A: if (running) st <= ST_FETCH_B;
                ST_FETCH_B: begin op_a  <= mem_q; st <= ST_FETCH_C; end
                ST_FETCH_C: begin op_b  <= mem_q; st <= ST_READ_A;  end
                ST_READ_A:  begin op_c  <= mem_q; st <= ST_READ_B;  end
                ST_READ_B:  begin val_a <= mem_q; st <= ST_WRITE;   end
                ST_WRITE: begin
                    take_q <= take;
                    res_q  <= diff;
                    st     <= ST_UPDATE_PC;
                end
                ST_UPDATE_PC: begin
                    pc <= pc_next;
                    st <= pc_next[W-1] ? ST_HALT : ST_FETCH_A;
                end
                default: st <= ST_HALT;
            endcase
        end
    end

    // R6: once stopped, the machine stays stopped.
    assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R6: counter is frozen while stopped.
    assert_pc_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc));

    // R6: no write-back while stopped.
    assert_no_write_halted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    // R7: the counter moves only in the update step.
    assert_pc_only_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_UPDATE_PC) |=> $stable(pc));

    // R8: a low enable holds the machine at the instruction boundary.
    assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FETCH_A && !running) |=> (st == ST_FETCH_A));

    // R3, R5: a taken branch always came from a result allowed by the mode.
    assert_taken_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_UPDATE_PC && take_q) |-> (res_q[W-1] || (ZERO_TAKES && res_q == '0)));

endmodule

// File: rtl/subbr_cpu.sv
// Module: top of the subtract-and-branch processor.
// Shares one RAM port between the core and the host: the host owns it while
// reset is held, after a halt, or while the core is stalled at an
// instruction boundary. Host writes are honoured only in reset.
module subbr_cpu #(
    parameter int  W          = 16,
    parameter int  DEPTH      = 384,
    parameter bit  ZERO_TAKES = 1'b1,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          running,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [W-1:0]  host_wdata,
    output logic [W-1:0]  host_rdata,
    output logic [W-1:0]  pc,
    output logic          halted
);

    logic [AW-1:0] core_addr, ram_addr;
    logic [W-1:0]  core_wdata, ram_wdata, ram_q;
    logic          core_we, core_owns, ram_we;
    logic [W-1:0]  minuend, subtrahend, diff;
    logic          take;

    // Purpose: arbitrate the single RAM port between host and core.
    always_comb begin
        ram_addr   = (rst_n && core_owns) ? core_addr : host_addr;
        ram_we     = rst_n ? (core_owns && core_we) : host_we;
        ram_wdata  = rst_n ? core_wdata : host_wdata;
        host_rdata = ram_q;
    end

    subbr_ram #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_q)
    );

    subbr_alu #(.W(W), .ZERO_TAKES(ZERO_TAKES)) u_alu (
        .minuend    (minuend),
        .subtrahend (subtrahend),
        .diff       (diff),
        .take       (take)
    );

    subbr_seq #(.W(W), .AW(AW), .ZERO_TAKES(ZERO_TAKES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .running    (running),
        .mem_q      (ram_q),
        .diff       (diff),
        .take       (take),
        .mem_addr   (core_addr),
        .mem_we     (core_we),
        .mem_wdata  (core_wdata),
        .core_owns  (core_owns),
        .minuend    (minuend),
        .subtrahend (subtrahend),
        .pc         (pc),
        .halted     (halted)
    );

    // R9: out of reset, every RAM write comes from the core's write-back.
    assert_host_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> core_we);

endmodule

// File: tb/tb_subbr_cpu.sv
`timescale 1ns/1ps
module tb_subbr_cpu;

    localparam int W  = 16;
    localparam int AW = 9;
    localparam int NV = 8;
    localparam logic [W-1:0] NEG1 = 16'hFFFF;

    // Vectors: source value, target value, branch with zero-takes rule, branch with strict rule.
    localparam logic [W-1:0] VA [NV] = '{16'd5, 16'd3, 16'd7, 16'd1, 16'hFFFF, 16'd0, 16'hFFFB, 16'd100};
    localparam logic [W-1:0] VB [NV] = '{16'd3, 16'd5, 16'd7, 16'h8000, 16'h7FFF, 16'd0, 16'hFFF6, 16'hFF9C};
    localparam bit BR1 [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
    localparam bit BR0 [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          running = 1'b1;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [W-1:0]  host_wdata = '0;
    logic [W-1:0]  rd1, rd0, pc1, pc0;
    logic          halt1, halt0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    subbr_cpu #(.W(W), .DEPTH(384), .ZERO_TAKES(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .running(running), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(rd1),
        .pc(pc1), .halted(halt1));

    subbr_cpu #(.W(W), .DEPTH(384), .ZERO_TAKES(1'b0)) dut_lt (
        .clk(clk), .rst_n(rst_n), .running(running), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(rd0),
        .pc(pc0), .halted(halt0));

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [W-1:0] d);
        host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic peek(input int a, output logic [W-1:0] q1, output logic [W-1:0] q0);
        host_addr = AW'(a);
        @(negedge clk);
        q1 = rd1; q0 = rd0;
    endtask

    // Hold reset, clear the low words, load the two-path test program.
    task automatic load_prog(input logic [W-1:0] va, input logic [W-1:0] vb);
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 48; i++) poke(i, '0);
        poke(0, 16'd10); poke(1, 16'd11); poke(2, 16'd20);
        poke(3, 16'd13); poke(4, 16'd12); poke(5, NEG1);
        poke(20, 16'd13); poke(21, 16'd14); poke(22, NEG1);
        poke(10, va); poke(11, vb); poke(13, 16'd1);
    endtask

    task automatic wait_halt();
        for (int i = 0; i < 500; i++) begin
            if (halt1 && halt0) break;
            @(negedge clk);
        end
        if (!(halt1 && halt0)) begin
            n_fail++;
            $display("FAIL R6 actual=running expected=halted");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] q1, q0, expv;
        @(negedge clk);

        // Vector table: each entry runs one subtract then one stop instruction.
        foreach (VA[v]) begin
            load_prog(VA[v], VB[v]);
            running = 1'b1;
            rst_n = 1'b1;
            wait_halt();
            expv = VB[v] - VA[v];
            peek(11, q1, q0);
            chk($sformatf("R2 v%0d diff", v), q1, expv);
            chk($sformatf("R2 v%0d diff strict", v), q0, expv);
            peek(14, q1, q0);
            chk($sformatf("R3 v%0d branch marker", v), q1, BR1[v] ? NEG1 : 16'd0);
            chk($sformatf("R5 v%0d strict marker", v), q0, BR0[v] ? NEG1 : 16'd0);
            peek(12, q1, q0);
            chk($sformatf("R4 v%0d fall-through marker", v), q1, BR1[v] ? 16'd0 : NEG1);
            chk($sformatf("R4 v%0d strict fall marker", v), q0, BR0[v] ? 16'd0 : NEG1);
            chk($sformatf("R6 v%0d pc", v), pc1, NEG1);
        end

        // R1: reset state, and the first clock after release.
        load_prog(16'd5, 16'd3);
        chk("R1 pc in reset", pc1, 16'd0);
        chk("R1 halted in reset", {15'd0, halt1}, 16'd0);
        peek(13, q1, q0);
        chk("R10 read in reset", q1, 16'd1);

        // R7: timed run, branch to 20 after 7 edges, stop on edge 14.
        running = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pc after release", pc1, 16'd0);
        chk("R1 halted after release", {15'd0, halt1}, 16'd0);
        repeat (5) @(negedge clk);
        chk("R7 pc before edge 7", pc1, 16'd0);
        @(negedge clk);
        chk("R7 pc after edge 7", pc1, 16'd20);
        repeat (6) @(negedge clk);
        chk("R7 not halted after edge 13", {15'd0, halt1}, 16'd0);
        @(negedge clk);
        chk("R7 halted after edge 14", {15'd0, halt1}, 16'd1);

        // R6: stays stopped, counter and memory frozen.
        repeat (30) @(negedge clk);
        chk("R6 still halted", {15'd0, halt1}, 16'd1);
        chk("R6 pc frozen", pc1, NEG1);
        peek(14, q1, q0);
        chk("R6 marker unchanged", q1, NEG1);

        // R9: host write out of reset is ignored.
        poke(11, 16'h1234);
        peek(11, q1, q0);
        chk("R9 host write ignored", q1, 16'hFFFE);
        peek(13, q1, q0);
        chk("R10 read after halt", q1, 16'd1);

        // R8: enable low holds the core at the first instruction.
        load_prog(16'd2, 16'd9);
        running = 1'b0;
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R8 pc held", pc1, 16'd0);
        chk("R8 not halted", {15'd0, halt1}, 16'd0);
        peek(11, q1, q0);
        chk("R8 memory untouched", q1, 16'd9);
        running = 1'b1;
        wait_halt();
        peek(11, q1, q0);
        chk("R8 resumes diff", q1, 16'd7);

        // R11: first instruction rewrites the jump word of the second.
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 48; i++) poke(i, '0);
        poke(0, 16'd30); poke(1, 16'd5);  poke(2, 16'd3);
        poke(3, 16'd31); poke(4, 16'd32); poke(5, 16'd40);
        poke(40, 16'd33); poke(41, 16'd34); poke(42, NEG1);
        poke(30, 16'd41); poke(31, 16'd1); poke(33, 16'd1);
        running = 1'b1;
        rst_n = 1'b1;
        wait_halt();
        peek(32, q1, q0);
        chk("R11 rewritten path taken", q1, NEG1);
        peek(34, q1, q0);
        chk("R11 stale path skipped", q1, 16'd0);
        chk("R11 pc", pc1, NEG1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule